// File: doc/BRIEF.md
# Signalling voltage switch sequencer

This block moves a memory-card host interface from 3.3 V to 1.8 V signalling, and back again, without software timing each step. A single-cycle request selects the target level. For the low-voltage target the sequencer stops the card clock and confirms that the four data lines are idle low. It then raises the 1.8 V signal-enable control, lets the regulator settle, restarts the clock and confirms that the card drives all data lines high. If any step fails, the sequencer power-cycles the bus and asks the next card initialisation to drop its 1.8 V request.

Millisecond delays come from a prescaler. It counts `CYC_PER_MS` system clocks per millisecond, and a millisecond counter is loaded for each wait. The command exchange with the card and the analog regulator are outside the block. The regulator is seen only through a feedback bit that shows whether the enable took effect.

Top module: `sig_volt_seq`

## Requirements
- R1: After reset, the card clock enable, the 1.8 V enable and the bus power enable are all 0, and the 1.8 V request flag is 1. `busy_o` and `done_o` are 0.
- R2: An accepted 1.8 V request clears the card clock enable at the request edge. The 1.8 V enable is raised only after the data lines have been sampled with the clock stopped.
- R3: If DAT[3:0] is not 4'b0000 at the line check, no voltage change is made and the failure path (R6) runs.
- R4: After a good line check, the 1.8 V enable is set and held for `SWITCH_MS` milliseconds (`SWITCH_MS*CYC_PER_MS` cycles). If the regulator feedback reads 0 at the end of that wait, the failure path runs.
- R5: If the feedback reads 1, the card clock is re-enabled for `RESTART_MS` milliseconds and DAT[3:0] is then sampled. The result is success only for 4'b1111, and any other value runs the failure path. A full successful switch completes `2 + (SWITCH_MS+RESTART_MS)*CYC_PER_MS` cycles after the request edge.
- R6: The failure path clears the 1.8 V enable and drops bus power for `PWR_OFF_MS` milliseconds. It then restores power, reports retry and clears the 1.8 V request flag.
- R7: A 3.3 V request clears the 1.8 V enable and waits `SWITCH_MS` milliseconds. It reports success if the feedback reads 0 and error if the feedback still reads 1.
- R8: A 1.8 V request while the 1.8 V enable is already set changes no output and reports success on the cycle after the request edge.
- R9: With `ctrl_v3_i` low, every request is a no-op that reports success on the cycle after the request edge.
- R10: Requests are accepted only while idle. A request made while `busy_o` is high changes neither the sequence nor its result.
- R11: `done_o` is a one-cycle pulse. At `done_o` exactly one of `ok_o`, `err_o`, `retry_o` is high, and all three hold until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Single-cycle switch request |
| req_low_i | input | 1 | Target level: 1 = 1.8 V, 0 = 3.3 V |
| ctrl_v3_i | input | 1 | Controller supports voltage switching |
| dat_lvl_i | input | 4 | Levels of DAT[3:0] |
| low_en_fb_i | input | 1 | Regulator feedback: 1.8 V enable reads set |
| card_clk_en_o | output | 1 | Card clock enable |
| low_sig_en_o | output | 1 | 1.8 V signal-enable control |
| bus_pwr_en_o | output | 1 | Bus power enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last request succeeded |
| err_o | output | 1 | Last 3.3 V request failed |
| retry_o | output | 1 | Last 1.8 V request failed; re-initialise |
| low_req_flag_o | output | 1 | Next initialisation should request 1.8 V |

## Verification
The bench drives each exit from the 1.8 V path: lines not idle at the check, feedback dropping during the settle, and wrong lines after the clock restart. In each case it measures the exact completion latency. A design that skipped the line check, restarted the clock early or miscounted a wait would finish on the wrong cycle or with the wrong status. The bench also probes mid-sequence state: enable high while the clock is still gated, and power low during the power-off window. A design that reordered the steps or never dropped power is caught there. A request injected while busy, an already-active request and a legacy-controller request confirm that none of these disturbs the outputs.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINE_CHK,
    ST_SETTLE_LOW,
    ST_CLK_RESTART,
    ST_PWR_OFF,
    ST_SETTLE_HIGH
  } svs_state_e;
endpackage

// File: rtl/svs_ms_timer.sv
module svs_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 4,
  localparam int PRE_W     = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expire_o
);
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;
  logic             ms_tick;

  assign ms_tick  = run_q && (pre_q == PRE_W'(CYC_PER_MS - 1));
  assign expire_o = ms_tick && (ms_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      pre_q <= '0;
      ms_q  <= ms_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (ms_tick) begin
        pre_q <= '0;
        ms_q  <= ms_q - MS_W'(1);
        if (ms_q == MS_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/svs_fsm.sv
module svs_fsm
  import svs_pkg::*;
#(
  parameter int MS_W       = 4,
  parameter int SWITCH_MS  = 5,
  parameter int RESTART_MS = 1,
  parameter int PWR_OFF_MS = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_low_i,
  input  logic            ctrl_v3_i,
  input  logic [3:0]      dat_lvl_i,
  input  logic            low_en_fb_i,
  input  logic            expire_i,
  output logic            tmr_start_o,
  output logic [MS_W-1:0] tmr_ms_o,
  output logic            card_clk_en_o,
  output logic            low_sig_en_o,
  output logic            bus_pwr_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            ok_o,
  output logic            err_o,
  output logic            retry_o,
  output logic            low_req_flag_o
);
  localparam logic [MS_W-1:0] SW_T  = MS_W'(SWITCH_MS);
  localparam logic [MS_W-1:0] RS_T  = MS_W'(RESTART_MS);
  localparam logic [MS_W-1:0] PO_T  = MS_W'(PWR_OFF_MS);

  svs_state_e st_q;
  logic       noop_req;
  logic       lines_idle, lines_high;

  assign lines_idle = (dat_lvl_i == 4'b0000);
  assign lines_high = (dat_lvl_i == 4'b1111);
  assign noop_req   = !ctrl_v3_i || (req_low_i && low_sig_en_o);
  assign busy_o     = (st_q != ST_IDLE);

  always_comb begin
    tmr_start_o = 1'b0;
    tmr_ms_o    = PO_T;
    unique case (st_q)
      ST_IDLE:
        if (req_valid_i && !noop_req && !req_low_i) begin
          tmr_start_o = 1'b1;
          tmr_ms_o    = SW_T;
        end
      ST_LINE_CHK: begin
        tmr_start_o = 1'b1;
        tmr_ms_o    = lines_idle ? SW_T : PO_T;
      end
      ST_SETTLE_LOW:
        if (expire_i) begin
          tmr_start_o = 1'b1;
          tmr_ms_o    = low_en_fb_i ? RS_T : PO_T;
        end
      ST_CLK_RESTART:
        if (expire_i && !lines_high) begin
          tmr_start_o = 1'b1;
          tmr_ms_o    = PO_T;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      card_clk_en_o  <= 1'b0;
      low_sig_en_o   <= 1'b0;
      bus_pwr_en_o   <= 1'b0;
      done_o         <= 1'b0;
      ok_o           <= 1'b0;
      err_o          <= 1'b0;
      retry_o        <= 1'b0;
      low_req_flag_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE:
          if (req_valid_i) begin
            ok_o    <= 1'b0;
            err_o   <= 1'b0;
            retry_o <= 1'b0;
            if (noop_req) begin
              done_o <= 1'b1;
              ok_o   <= 1'b1;
            end else if (req_low_i) begin
              card_clk_en_o <= 1'b0;
              st_q          <= ST_LINE_CHK;
            end else begin
              low_sig_en_o <= 1'b0;
              st_q         <= ST_SETTLE_HIGH;
            end
          end
        ST_LINE_CHK:
          if (lines_idle) begin
            low_sig_en_o <= 1'b1;
            st_q         <= ST_SETTLE_LOW;
          end else begin
            low_sig_en_o <= 1'b0;
            bus_pwr_en_o <= 1'b0;
            st_q         <= ST_PWR_OFF;
          end
        ST_SETTLE_LOW:
          if (expire_i) begin
            if (low_en_fb_i) begin
              card_clk_en_o <= 1'b1;
              st_q          <= ST_CLK_RESTART;
            end else begin
              low_sig_en_o <= 1'b0;
              bus_pwr_en_o <= 1'b0;
              st_q         <= ST_PWR_OFF;
            end
          end
        ST_CLK_RESTART:
          if (expire_i) begin
            if (lines_high) begin
              done_o <= 1'b1;
              ok_o   <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              low_sig_en_o <= 1'b0;
              bus_pwr_en_o <= 1'b0;
              st_q         <= ST_PWR_OFF;
            end
          end
        ST_PWR_OFF:
          if (expire_i) begin
            bus_pwr_en_o   <= 1'b1;
            low_req_flag_o <= 1'b0;
            done_o         <= 1'b1;
            retry_o        <= 1'b1;
            st_q           <= ST_IDLE;
          end
        ST_SETTLE_HIGH:
          if (expire_i) begin
            done_o <= 1'b1;
            ok_o   <= !low_en_fb_i;
            err_o  <= low_en_fb_i;
            st_q   <= ST_IDLE;
          end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sig_volt_seq.sv
module sig_volt_seq #(
  parameter int CYC_PER_MS = 50000,
  parameter int SWITCH_MS  = 5,
  parameter int RESTART_MS = 1,
  parameter int PWR_OFF_MS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       req_low_i,
  input  logic       ctrl_v3_i,
  input  logic [3:0] dat_lvl_i,
  input  logic       low_en_fb_i,
  output logic       card_clk_en_o,
  output logic       low_sig_en_o,
  output logic       bus_pwr_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       err_o,
  output logic       retry_o,
  output logic       low_req_flag_o
);
  localparam int MAX_MS = (SWITCH_MS > RESTART_MS) ?
                          ((SWITCH_MS > PWR_OFF_MS) ? SWITCH_MS : PWR_OFF_MS) :
                          ((RESTART_MS > PWR_OFF_MS) ? RESTART_MS : PWR_OFF_MS);
  localparam int MS_W = $clog2(MAX_MS + 1);

  logic            tmr_start;
  logic [MS_W-1:0] tmr_ms;
  logic            tmr_expire;

  svs_ms_timer #(
    .CYC_PER_MS(CYC_PER_MS),
    .MS_W      (MS_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .ms_i    (tmr_ms),
    .expire_o(tmr_expire)
  );

  svs_fsm #(
    .MS_W      (MS_W),
    .SWITCH_MS (SWITCH_MS),
    .RESTART_MS(RESTART_MS),
    .PWR_OFF_MS(PWR_OFF_MS)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_low_i     (req_low_i),
    .ctrl_v3_i     (ctrl_v3_i),
    .dat_lvl_i     (dat_lvl_i),
    .low_en_fb_i   (low_en_fb_i),
    .expire_i      (tmr_expire),
    .tmr_start_o   (tmr_start),
    .tmr_ms_o      (tmr_ms),
    .card_clk_en_o (card_clk_en_o),
    .low_sig_en_o  (low_sig_en_o),
    .bus_pwr_en_o  (bus_pwr_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .ok_o          (ok_o),
    .err_o         (err_o),
    .retry_o       (retry_o),
    .low_req_flag_o(low_req_flag_o)
  );
endmodule

// File: rtl/sig_volt_seq_chk.sv
module sig_volt_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic card_clk_en_o,
  input logic low_sig_en_o,
  input logic bus_pwr_en_o,
  input logic busy_o,
  input logic done_o,
  input logic ok_o,
  input logic err_o,
  input logic retry_o,
  input logic low_req_flag_o
);
  // R2
  en_after_clk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_sig_en_o) |-> !card_clk_en_o);

  // R5
  clk_restart_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_en_o) |-> low_sig_en_o);

  // R6
  retry_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && retry_o) |-> (!low_req_flag_o && bus_pwr_en_o));

  // R6
  pwr_drop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_pwr_en_o) |-> busy_o);

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  one_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({ok_o, err_o, retry_o}));

  // R11
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable({ok_o, err_o, retry_o}) || done_o || !busy_o);
endmodule

bind sig_volt_seq sig_volt_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .card_clk_en_o (card_clk_en_o),
  .low_sig_en_o  (low_sig_en_o),
  .bus_pwr_en_o  (bus_pwr_en_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .ok_o          (ok_o),
  .err_o         (err_o),
  .retry_o       (retry_o),
  .low_req_flag_o(low_req_flag_o)
);

// File: tb/sig_volt_seq_bench.sv
`timescale 1ns/1ps
module sig_volt_seq_bench;
  localparam int CYC = 10;
  localparam int SW  = 5;
  localparam int RS  = 1;
  localparam int PO  = 1;

  localparam int LAT_NOOP  = 1;
  localparam int LAT_LOW   = 2 + (SW + RS) * CYC;
  localparam int LAT_DATF  = 2 + PO * CYC;
  localparam int LAT_FBF   = 2 + (SW + PO) * CYC;
  localparam int LAT_VERF  = 2 + (SW + RS + PO) * CYC;
  localparam int LAT_HIGH  = 1 + SW * CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_low = 1'b0, ctrl_v3 = 1'b1;
  logic [3:0] dat;
  logic fb;
  logic card_clk_en, low_sig_en, bus_pwr_en, busy, done, ok, err, retry, low_req_flag;

  // 0: card model, 1: lines stuck 0100, 2: lines 0111 after restart
  int dat_mode = 0;
  // 0: follows enable, 1: stuck 0, 2: stuck 1
  int fb_mode = 0;

  int n_chk = 0, n_fail = 0;
  logic p_clk, p_en, p_pwr;

  always #10 clk = ~clk;

  always_comb begin
    case (dat_mode)
      1:       dat = 4'b0100;
      2:       dat = card_clk_en ? 4'b0111 : 4'b0000;
      default: dat = card_clk_en ? 4'b1111 : 4'b0000;
    endcase
    case (fb_mode)
      1:       fb = 1'b0;
      2:       fb = 1'b1;
      default: fb = low_sig_en;
    endcase
  end

  sig_volt_seq #(.CYC_PER_MS(CYC), .SWITCH_MS(SW), .RESTART_MS(RS), .PWR_OFF_MS(PO))
  u_sig_volt_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_low_i(req_low),
    .ctrl_v3_i(ctrl_v3), .dat_lvl_i(dat), .low_en_fb_i(fb),
    .card_clk_en_o(card_clk_en), .low_sig_en_o(low_sig_en), .bus_pwr_en_o(bus_pwr_en),
    .busy_o(busy), .done_o(done), .ok_o(ok), .err_o(err), .retry_o(retry),
    .low_req_flag_o(low_req_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one request; returns latency in cycles until done_o is seen
  task automatic run_req(input logic low, input int probe_n, input bit inject,
                         output int lat);
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_low   = low;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!done && n < 2000) begin
      if (n == probe_n) begin
        p_clk = card_clk_en; p_en = low_sig_en; p_pwr = bus_pwr_en;
      end
      if (inject && n == 5) begin
        req_valid = 1'b1;
        req_low   = ~low;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    lat = n;
  endtask

  task automatic after_done();
    @(negedge clk);
    check("R11 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    check("R1 clk off", card_clk_en, 0);
    check("R1 enable clear", low_sig_en, 0);
    check("R1 power off", bus_pwr_en, 0);
    check("R1 flag set", low_req_flag, 1);
    check("R1 idle", busy, 0);
    check("R1 no done", done, 0);
  endtask

  task automatic t_low_ok();
    int lat;
    run_req(1'b1, 3, 1'b0, lat);
    check("R2 clk gated at settle", p_clk, 0);
    check("R4 enable set at settle", p_en, 1);
    check("R5 latency", lat, LAT_LOW);
    check("R5 ok", ok, 1);
    check("R5 clk on", card_clk_en, 1);
    check("R11 single status", err + retry, 0);
    check("R5 flag kept", low_req_flag, 1);
    after_done();
  endtask

  task automatic t_low_again();
    int lat;
    run_req(1'b1, 0, 1'b0, lat);
    check("R8 latency", lat, LAT_NOOP);
    check("R8 ok", ok, 1);
    check("R8 enable kept", low_sig_en, 1);
    check("R8 clk kept", card_clk_en, 1);
    after_done();
  endtask

  task automatic t_legacy();
    int lat;
    ctrl_v3 = 1'b0;
    run_req(1'b0, 0, 1'b0, lat);
    check("R9 latency", lat, LAT_NOOP);
    check("R9 ok", ok, 1);
    check("R9 enable kept", low_sig_en, 1);
    ctrl_v3 = 1'b1;
    after_done();
  endtask

  task automatic t_high_busy();
    int lat;
    run_req(1'b0, 0, 1'b1, lat);
    check("R10 R7 latency", lat, LAT_HIGH);
    check("R7 ok", ok, 1);
    check("R7 enable cleared", low_sig_en, 0);
    after_done();
    check("R10 stays idle", busy, 0);
    check("R10 enable unchanged", low_sig_en, 0);
  endtask

  task automatic t_high_stuck();
    int lat;
    fb_mode = 2;
    run_req(1'b0, 0, 1'b0, lat);
    check("R7 stuck latency", lat, LAT_HIGH);
    check("R7 err", err, 1);
    check("R7 no ok", ok, 0);
    fb_mode = 0;
    after_done();
  endtask

  task automatic t_fb_fail();
    int lat;
    fb_mode = 1;
    run_req(1'b1, 0, 1'b0, lat);
    check("R4 fb fail latency", lat, LAT_FBF);
    check("R6 retry", retry, 1);
    check("R6 flag cleared", low_req_flag, 0);
    check("R6 power back", bus_pwr_en, 1);
    check("R6 enable cleared", low_sig_en, 0);
    fb_mode = 0;
    after_done();
  endtask

  task automatic t_dat_fail();
    int lat;
    dat_mode = 1;
    run_req(1'b1, 3, 1'b0, lat);
    check("R6 power off window", p_pwr, 0);
    check("R3 no enable", p_en, 0);
    check("R3 latency", lat, LAT_DATF);
    check("R3 retry", retry, 1);
    check("R6 power restored", bus_pwr_en, 1);
    dat_mode = 0;
    after_done();
  endtask

  task automatic t_verify_fail();
    int lat;
    dat_mode = 2;
    run_req(1'b1, 0, 1'b0, lat);
    check("R5 verify fail latency", lat, LAT_VERF);
    check("R5 retry", retry, 1);
    check("R5 no ok", ok, 0);
    check("R6 enable cleared", low_sig_en, 0);
    dat_mode = 0;
    after_done();
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_ok();
    t_low_again();
    t_legacy();
    t_high_busy();
    t_high_stuck();
    t_fb_fail();
    t_dat_fail();
    t_verify_fail();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule